// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-up

This block is a watchdog that counts on its own free-running tick clock, apart from the core clock, so it keeps counting while the core is stopped in sleep. A base counter of parameterised width feeds a postscaler whose ratio comes from static configuration pins. When the chain reaches its terminal count the block raises one of two requests. While the core is awake it asks for a device reset. While the core sleeps it asks for a wake-up, and the core then resumes. An active-low flag records that a time-out happened.

The core uses two strobes to restart the count: one for the clear-watchdog instruction and one for sleep entry. Each strobe passes through a synchronizer and acts once, on its rising edge. The enable has two levels. A hardware configuration pin forces the timer on. When that pin is low, bit 0 of a byte-wide control register turns the timer on or off. The register port is clocked by the watchdog tick. Any bridge from the core clock is outside the block.

Top module: `wdg_watchdog`

## Requirements
- R1: A time-out while the synchronized sleep flag is low raises `reset_req_o` for exactly one tick cycle, and `wake_req_o` stays low.
- R2: A time-out while the synchronized sleep flag is high raises `wake_req_o` for exactly one tick cycle, and `reset_req_o` stays low. The two requests are never high together.
- R3: `to_n_o` is 1 after power-on reset. It goes to 0 in the same cycle as each time-out request. A clear or sleep-entry restart sets it back to 1, and only a time-out clears it.
- R4: While `hw_en_i` is 1 the timer runs and times out whatever value software writes to the control register.
- R5: While `hw_en_i` is 0, control bit 0 alone gates the timer. With the bit at 1 the timer runs. With the bit at 0 the timer produces no request and holds its count.
- R6: The control register is one byte. Bit 0 is the software enable: it can be written and read back, and it is 0 after reset. Bits 7 to 1 always read 0, whatever is written to them.
- R7: A restart, from either strobe, zeroes the base counter and the postscaler count. No request follows for at least one full period after it. The postscaler ratio is left unchanged.
- R8: `ps_sel_i` values 0 through 7 select postscaler divides of 1, 2, 4, 8, 16, 32, 64 and 128. From a zeroed count, with the timer running every tick, the request appears after exactly 2^BASE_W × 2^`ps_sel_i` tick edges.
- R9: Each strobe passes through a SYNC_STAGES-flop synchronizer and restarts the count once, on its rising edge. A strobe held high does not restart the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Free-running watchdog tick clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| hw_en_i | input | 1 | Configuration pin that forces the timer on |
| ps_sel_i | input | SEL_W | Static postscaler ratio select (divide by 2^value) |
| clr_strobe_i | input | 1 | Clear-watchdog strobe from the core, asynchronous to `wd_clk` |
| sleep_strobe_i | input | 1 | Sleep-entry strobe from the core, asynchronous to `wd_clk` |
| sleep_i | input | 1 | Level that is high while the core is in sleep |
| reg_wr_i | input | 1 | Write enable for the control register |
| reg_wdata_i | input | 8 | Write data for the control register |
| reg_rdata_o | output | 8 | Read data from the control register |
| reset_req_o | output | 1 | One-cycle device reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Time-out flag, low after a time-out |

## Verification
The bench builds the block with BASE_W = 4, SEL_W = 3 and SYNC_STAGES = 2. A full period is then between 16 and 2048 tick cycles, so every postscaler ratio from 1 to 128 can be timed exactly within a short run. Using two synchronizer stages makes the strobe-to-restart delay a small fixed number of cycles. That keeps the windows around a restart tight enough to show a strobe held high for longer than a whole period still restarts the count only once.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned CTRL_W   = 8;
   localparam int unsigned SWEN_BIT = 0;

   typedef logic [CTRL_W-1:0] ctrl_byte_t;

   // Builds the read image of the control register from the enable bit alone.
   function automatic ctrl_byte_t ctrl_image(input logic swen);
      ctrl_byte_t img;
      img           = '0;
      img[SWEN_BIT] = swen;
      return img;
   endfunction
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wdg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  ctrl_byte_t wdata_i,
   output ctrl_byte_t rdata_o,
   output logic       swen_o
);
   logic swen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    swen_q <= 1'b0;
      else if (wr_i) swen_q <= wdata_i[SWEN_BIT];
   end

   assign swen_o  = swen_q;
   assign rdata_o = ctrl_image(swen_q);
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int unsigned BASE_W = 10,
   parameter int unsigned SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             expire_o
);
   localparam int unsigned PS_W = (1 << SEL_W) - 1;

   if (BASE_W < 2) begin : g_bad_base
      $error("wdg_count: BASE_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("wdg_count: SEL_W must lie in 1..4");
   end

   logic [BASE_W-1:0] base_q;
   logic [PS_W-1:0]   ps_q;
   logic [PS_W-1:0]   ps_last;
   logic              base_wrap;
   logic              ps_hit;

   // Terminal postscaler count is 2^sel - 1: a thermometer of sel ones.
   for (genvar i = 0; i < PS_W; i++) begin : g_term
      assign ps_last[i] = (i < int'(sel_i));
   end

   assign base_wrap = run_i && (&base_q);
   assign ps_hit    = (ps_q == ps_last);
   assign expire_o  = base_wrap && ps_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ps_q   <= '0;
      end else if (restart_i) begin
         base_q <= '0;
         ps_q   <= '0;
      end else if (run_i) begin
         base_q <= base_q + 1'b1;
         if (base_wrap) ps_q <= ps_hit ? '0 : ps_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdg_watchdog.sv
module wdg_watchdog
   import wdg_pkg::*;
#(
   parameter int unsigned BASE_W      = 10,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             wd_clk,
   input  logic             por_n,
   input  logic             hw_en_i,
   input  logic [SEL_W-1:0] ps_sel_i,
   input  logic             clr_strobe_i,
   input  logic             sleep_strobe_i,
   input  logic             sleep_i,
   input  logic             reg_wr_i,
   input  logic [7:0]       reg_wdata_i,
   output logic [7:0]       reg_rdata_o,
   output logic             reset_req_o,
   output logic             wake_req_o,
   output logic             to_n_o
);
   logic clr_lvl, slp_lvl, sleep_lvl;
   logic clr_lvl_d, slp_lvl_d;
   logic restart, run, expire, swen;
   logic reset_q, wake_q, to_n_q;

   wdg_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
      .clk(wd_clk), .rst_n(por_n), .d_i(clr_strobe_i), .q_o(clr_lvl));
   wdg_sync #(.STAGES(SYNC_STAGES)) u_sync_slp (
      .clk(wd_clk), .rst_n(por_n), .d_i(sleep_strobe_i), .q_o(slp_lvl));
   wdg_sync #(.STAGES(SYNC_STAGES)) u_sync_state (
      .clk(wd_clk), .rst_n(por_n), .d_i(sleep_i), .q_o(sleep_lvl));

   always_ff @(posedge wd_clk or negedge por_n) begin
      if (!por_n) begin
         clr_lvl_d <= 1'b0;
         slp_lvl_d <= 1'b0;
      end else begin
         clr_lvl_d <= clr_lvl;
         slp_lvl_d <= slp_lvl;
      end
   end

   assign restart = (clr_lvl & ~clr_lvl_d) | (slp_lvl & ~slp_lvl_d);

   wdg_ctrl_reg u_ctrl (
      .clk(wd_clk), .rst_n(por_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
      .rdata_o(reg_rdata_o), .swen_o(swen));

   assign run = hw_en_i | swen;

   wdg_count #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_count (
      .clk(wd_clk), .rst_n(por_n), .run_i(run), .restart_i(restart),
      .sel_i(ps_sel_i), .expire_o(expire));

   // A restart in the same cycle as expiry wins: the count is zeroed, no request.
   always_ff @(posedge wd_clk or negedge por_n) begin
      if (!por_n) begin
         reset_q <= 1'b0;
         wake_q  <= 1'b0;
         to_n_q  <= 1'b1;
      end else begin
         reset_q <= expire & ~restart & ~sleep_lvl;
         wake_q  <= expire & ~restart &  sleep_lvl;
         if (restart)     to_n_q <= 1'b1;
         else if (expire) to_n_q <= 1'b0;
      end
   end

   assign reset_req_o = reset_q;
   assign wake_req_o  = wake_q;
   assign to_n_o      = to_n_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
   input logic       wd_clk,
   input logic       por_n,
   input logic       hw_en_i,
   input logic [7:0] reg_rdata_o,
   input logic       reset_req_o,
   input logic       wake_req_o,
   input logic       to_n_o
);
   AST_REQ_EXCLUSIVE: assert property (@(posedge wd_clk) disable iff (!por_n)
      !(reset_req_o && wake_req_o)); // R2
   AST_RESET_ONE_CYCLE: assert property (@(posedge wd_clk) disable iff (!por_n)
      reset_req_o |=> !reset_req_o); // R1
   AST_WAKE_ONE_CYCLE: assert property (@(posedge wd_clk) disable iff (!por_n)
      wake_req_o |=> !wake_req_o); // R2
   AST_FLAG_ON_TIMEOUT: assert property (@(posedge wd_clk) disable iff (!por_n)
      (reset_req_o || wake_req_o) |-> !to_n_o); // R3
   AST_UPPER_BITS_ZERO: assert property (@(posedge wd_clk) disable iff (!por_n)
      reg_rdata_o[7:1] == 7'd0); // R6
   AST_OFF_NO_REQUEST: assert property (@(posedge wd_clk) disable iff (!por_n)
      $past(!hw_en_i && !reg_rdata_o[0]) |-> !(reset_req_o || wake_req_o)); // R5
endmodule

bind wdg_watchdog wdg_chk u_chk (
   .wd_clk(wd_clk), .por_n(por_n), .hw_en_i(hw_en_i), .reg_rdata_o(reg_rdata_o),
   .reset_req_o(reset_req_o), .wake_req_o(wake_req_o), .to_n_o(to_n_o));

// File: tb/wdg_watchdog_bench.sv
module wdg_watchdog_bench;
   localparam int unsigned BASE_W = 4;
   localparam int unsigned SEL_W  = 3;

   logic       wd_clk = 1'b0;
   logic       por_n  = 1'b0;
   logic       hw_en  = 1'b0;
   logic [2:0] ps_sel = '0;
   logic       clr_s  = 1'b0;
   logic       slp_s  = 1'b0;
   logic       sleep  = 1'b0;
   logic       wr     = 1'b0;
   logic [7:0] wdata  = '0;
   logic [7:0] rdata;
   logic       rst_req, wake_req, to_n;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   wdg_watchdog #(.BASE_W(BASE_W), .SEL_W(SEL_W), .SYNC_STAGES(2)) u_wdg_watchdog (
      .wd_clk(wd_clk), .por_n(por_n), .hw_en_i(hw_en), .ps_sel_i(ps_sel),
      .clr_strobe_i(clr_s), .sleep_strobe_i(slp_s), .sleep_i(sleep),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .reset_req_o(rst_req), .wake_req_o(wake_req), .to_n_o(to_n));

   always #5 wd_clk = ~wd_clk;

   always @(posedge wd_clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int period(input int sel);
      return (1 << BASE_W) << sel;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge wd_clk);
      @(negedge wd_clk);
   endtask

   task automatic do_reset(input logic hw, input int sel);
      @(negedge wd_clk);
      por_n = 1'b0; hw_en = hw; ps_sel = 3'(sel);
      clr_s = 0; slp_s = 0; wr = 0;
      step();
      por_n = 1'b1;
   endtask

   task automatic write(input logic [7:0] v);
      wr = 1'b1; wdata = v;
      step();
      wr = 1'b0;
   endtask

   // Counts edges until either request is seen; returns limit+1 if none.
   task automatic wait_req(input int limit, output int n);
      n = limit + 1;
      for (int i = 1; i <= limit; i++) begin
         step();
         if (rst_req || wake_req) begin n = i; break; end
      end
   endtask

   int n, p, sel;
   logic sw_mode, slp;

   initial begin
      // Reset state
      do_reset(1'b0, 0);
      check("R6 rdata after reset", rdata, 0);
      check("R3 to_n after reset", to_n, 1);
      check("R1 no request after reset", rst_req | wake_req, 0);

      // Register image
      write(8'hFF);
      check("R6 write FF reads 01", rdata, 8'h01);
      write(8'hFE);
      check("R6 write FE reads 00", rdata, 8'h00);

      // Off: hardware enable low, software bit low
      do_reset(1'b0, 0);
      wait_req(3 * period(0), n);
      check("R5 disabled gives no request", n, 3 * period(0) + 1);

      // Constrained random periods, modes and sleep state
      void'($urandom(32'h5EED_0417));
      for (int it = 0; it < 10; it++) begin
         sel     = (it < 8) ? it : int'($urandom_range(7, 0));
         sw_mode = 1'($urandom_range(1, 0));
         slp     = 1'($urandom_range(1, 0));
         p       = period(sel);
         sleep   = slp;
         do_reset(!sw_mode, sel);
         if (sw_mode) write(8'h01);
         else         write(8'(($urandom_range(1, 0)) * 2)); // R4 software write ignored
         if (!sw_mode) p = p - 1; // write step already counted one edge
         wait_req(p + 4, n);
         check(sw_mode ? "R5 software-enabled period" : "R8 hardware-enabled period", n, p);
         check(slp ? "R2 wake request when asleep" : "R1 reset request when awake",
               slp ? wake_req : rst_req, 1);
         check("R2 other request stays low", slp ? rst_req : wake_req, 0);
         check("R3 to_n low on time-out", to_n, 0);
         step();
         check("R1 request lasts one cycle", rst_req | wake_req, 0);
      end
      sleep = 1'b0;

      // Directed: hardware enable overrides a software stop
      do_reset(1'b1, 1);
      write(8'h00);
      wait_req(period(1) + 4, n);
      check("R4 hardware enable keeps timer on", n, period(1) - 1);

      // Clear strobe restores flag and restarts count; a held strobe acts once
      step();
      clr_s = 1'b1;
      n = 0;
      for (int i = 1; i <= 4; i++) step();
      check("R3 clear strobe sets to_n", to_n, 1);
      wait_req(period(1) + 8, n);
      check("R9 held strobe restarts once", (n + 4 >= period(1) + 2) && (n + 4 <= period(1) + 4), 1);
      clr_s = 1'b0;

      // Periodic clears prevent any time-out
      do_reset(1'b1, 0);
      n = 0;
      for (int k = 0; k < 8; k++) begin
         clr_s = 1'b1; step(); step(); clr_s = 1'b0;
         for (int i = 0; i < period(0) / 2; i++) begin
            step();
            if (rst_req || wake_req) n++;
         end
      end
      check("R7 periodic clear prevents time-out", n, 0);

      // Sleep-entry strobe restarts in the same way, ratio unchanged
      do_reset(1'b1, 2);
      for (int i = 0; i < period(2) - 10; i++) step();
      slp_s = 1'b1; step(); step(); slp_s = 1'b0;
      wait_req(period(2) + 8, n);
      check("R7 sleep strobe restarts full period", (n + 2 >= period(2) + 2) && (n + 2 <= period(2) + 4), 1);

      // Software stop holds the count
      do_reset(1'b0, 0);
      write(8'h01);
      for (int i = 0; i < 5; i++) step();
      write(8'h00);
      wait_req(3 * period(0), n);
      check("R5 software stop holds timer", n, 3 * period(0) + 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule